// File: doc/BRIEF.md
# Two-Channel Comparator Output Conditioner

This block is the digital back end that sits behind a pair of analog comparators. For each channel it takes the raw comparison bit, optionally inverts it, and then suppresses it while a selected blanking strobe is high. Blanking strobes normally come from timer compare outputs. They hide the current spikes that follow a switching edge. The conditioned value goes straight to a wakeup line and to the output pins through logic that needs no clock, so it keeps working while the bus clock is stopped.

A second, clocked path brings each conditioned value into the bus clock domain through a two-flop synchronizer. It then sets a sticky per-channel interrupt flag when that channel's interrupt enable is on. A one-cycle clear pulse from the register bank clears a flag. Both flags are merged into a single interrupt line.

Eleven output pins each carry one channel. An 11-bit routing field picks, pin by pin, which channel drives that pin.

Top module: `cmp_out_cond`

## Requirements
- R1: With blanking code 0, a channel's output equals its raw bit XOR its polarity bit, provided its enable bit is high.
- R2: A blanking code k from 1 to 6 selects strobe k, which is bit k-1 of `blankStrobe`. While that strobe is high, the channel output is 0.
- R3: A blanking code from 7 to 15 is reserved and behaves as code 0. No strobe affects the output.
- R4: The polarity bit inverts the raw result before the blanking gate. A channel whose enable bit is low drives 0 whatever the other inputs are.
- R5: The wakeup output of each channel equals its conditioned output. The wakeup and pin outputs follow the inputs combinationally, without any clock edge.
- R6: If a channel's conditioned output is high before clock edge k, and that channel's interrupt enable is high before edge k+2, the flag is set after edge k+2. With the interrupt enable low, the flag is not set.
- R7: A set flag stays set until a clear pulse for that channel (`flagClear` bit 0 for channel 1, bit 1 for channel 2) is sampled in a cycle with no set condition. The flag is then 0 after that edge.
- R8: When a set condition and a clear pulse for the same channel meet in one cycle, the flag is set after that edge.
- R9: The interrupt line is the OR of the two channel flags.
- R10: Pin p (p = 0 to 10) carries channel 1's output when bit p of `pinRoute` is 0, and channel 2's output when it is 1.
- R11: While reset is asserted (`rstN` low), both flags and the interrupt line are 0 and the synchronizers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for the flag path |
| rstN | input | 1 | Asynchronous active-low reset |
| rawCmp | input | 2 | Raw comparator bits, bit 0 = channel 1 |
| chanEnable | input | 2 | Per-channel enable |
| polarityInv | input | 2 | Per-channel inversion select |
| blankSel | input | 8 | Blanking codes, bits 3:0 channel 1, bits 7:4 channel 2 |
| blankStrobe | input | 6 | Blanking strobes 1 to 6 on bits 0 to 5 |
| irqEnable | input | 2 | Per-channel interrupt enable |
| flagClear | input | 2 | One-cycle write-one clear pulses |
| pinRoute | input | 11 | Per-pin channel select |
| chanOut | output | 2 | Conditioned channel values |
| wakeOut | output | 2 | Wakeup lines |
| irqFlag | output | 2 | Sticky interrupt flags |
| irqLine | output | 1 | Combined interrupt |
| pinOut | output | 11 | Routed pin outputs |

## Verification
On every cycle, the assertions check several rules: a disabled channel stays low, a high strobe 1 blanks any channel that selects it, and a flag holds until cleared. They also check that a set strobe beats a clear in the same cycle, that a clear alone drops the flag, and that the interrupt line changes only with a flag. Other behaviour shows only in the bench scenarios. These are the two-edge synchronizer latency, the treatment of reserved blanking codes, the pin-by-pin routing under changing route patterns, and the inversion ahead of blanking. A behavioural model tracks each of these every clock.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] setStb;
    logic [NUM_CH-1:0] clrStb;
  } flagStrobes_t;
endpackage

// File: rtl/cmp_cond_datapath.sv
module cmp_cond_datapath
  import cmp_cond_pkg::*;
#(
  parameter int NUM_BLANK = 6,
  parameter int SEL_W     = 4,
  parameter int NUM_PINS  = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         rawCmp,
  input  logic [NUM_CH-1:0]         chanEnable,
  input  logic [NUM_CH-1:0]         polarityInv,
  input  logic [NUM_CH*SEL_W-1:0]   blankSel,
  input  logic [NUM_BLANK-1:0]      blankStrobe,
  input  logic [NUM_PINS-1:0]       pinRoute,
  input  flagStrobes_t              strobes,
  output logic [NUM_CH-1:0]         chanOut,
  output logic [NUM_CH-1:0]         wakeOut,
  output logic [NUM_PINS-1:0]       pinOut,
  output logic [NUM_CH-1:0]         irqFlag
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SEL_W-1:0] selCode;
    logic             blankActive;
    logic             polOut;

    assign selCode = blankSel[c*SEL_W +: SEL_W];

    always_comb begin
      blankActive = 1'b0;
      for (int b = 0; b < NUM_BLANK; b++) begin
        if (selCode == SEL_W'(b + 1)) blankActive = blankStrobe[b];
      end
    end

    assign polOut     = rawCmp[c] ^ polarityInv[c];
    assign chanOut[c] = chanEnable[c] & polOut & ~blankActive;
    assign wakeOut[c] = chanOut[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqFlag[c] <= 1'b0;
      else if (strobes.setStb[c]) irqFlag[c] <= 1'b1;
      else if (strobes.clrStb[c]) irqFlag[c] <= 1'b0;
    end

    // R4: a disabled channel never drives high
    a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
      !chanEnable[c] |-> !chanOut[c]);
    // R2: strobe 1 selected and high blanks the channel
    a_r2_blank_gate: assert property (@(posedge clk) disable iff (!rstN)
      (blankSel[c*SEL_W +: SEL_W] == SEL_W'(1) && blankStrobe[0]) |-> !chanOut[c]);
    // R7: flag holds while no clear arrives
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
      (irqFlag[c] && !strobes.clrStb[c]) |=> irqFlag[c]);
    // R7: a lone clear drops the flag
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrStb[c] && !strobes.setStb[c]) |=> !irqFlag[c]);
    // R8: set wins over clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setStb[c] |=> irqFlag[c]);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pinOut[p] = pinRoute[p] ? chanOut[1] : chanOut[0];
  end
endmodule

// File: rtl/cmp_cond_ctrl.sv
module cmp_cond_ctrl
  import cmp_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanOut,
  input  logic [NUM_CH-1:0] irqEnable,
  input  logic [NUM_CH-1:0] flagClear,
  input  logic [NUM_CH-1:0] irqFlag,
  output flagStrobes_t      strobes,
  output logic              irqLine
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
    logic [SYNC_STAGES-1:0] syncSh;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncSh <= '0;
      else       syncSh <= {syncSh[LAST-1:0], chanOut[c]};
    end

    assign strobes.setStb[c] = syncSh[LAST] & irqEnable[c];
    assign strobes.clrStb[c] = flagClear[c];
  end

  assign irqLine = |irqFlag;

  // R9: the shared line moves only when a flag moves
  a_r9_irq_follows_flags: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irqLine) |-> !$stable(irqFlag));
endmodule

// File: rtl/cmp_out_cond.sv
module cmp_out_cond
  import cmp_cond_pkg::*;
#(
  parameter int NUM_BLANK   = 6,
  parameter int SEL_W       = 4,
  parameter int NUM_PINS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              rawCmp,
  input  logic [1:0]              chanEnable,
  input  logic [1:0]              polarityInv,
  input  logic [2*SEL_W-1:0]      blankSel,
  input  logic [NUM_BLANK-1:0]    blankStrobe,
  input  logic [1:0]              irqEnable,
  input  logic [1:0]              flagClear,
  input  logic [NUM_PINS-1:0]     pinRoute,
  output logic [1:0]              chanOut,
  output logic [1:0]              wakeOut,
  output logic [1:0]              irqFlag,
  output logic                    irqLine,
  output logic [NUM_PINS-1:0]     pinOut
);
  flagStrobes_t strobes;

  cmp_cond_datapath #(
    .NUM_BLANK(NUM_BLANK), .SEL_W(SEL_W), .NUM_PINS(NUM_PINS)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .chanEnable(chanEnable),
    .polarityInv(polarityInv), .blankSel(blankSel), .blankStrobe(blankStrobe),
    .pinRoute(pinRoute), .strobes(strobes), .chanOut(chanOut),
    .wakeOut(wakeOut), .pinOut(pinOut), .irqFlag(irqFlag)
  );

  cmp_cond_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .chanOut(chanOut), .irqEnable(irqEnable),
    .flagClear(flagClear), .irqFlag(irqFlag), .strobes(strobes),
    .irqLine(irqLine)
  );
endmodule

// File: tb/cmp_out_cond_tb_top.sv
module cmp_out_cond_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  rawCmp = '0, chanEnable = '0, polarityInv = '0;
  logic [7:0]  blankSel = '0;
  logic [5:0]  blankStrobe = '0;
  logic [1:0]  irqEnable = '0, flagClear = '0;
  logic [10:0] pinRoute = '0;
  logic [1:0]  chanOut, wakeOut, irqFlag;
  logic        irqLine;
  logic [10:0] pinOut;

  int checks = 0, failures = 0;
  bit done = 0;
  bit histQ[2][$];
  bit modelFlag[2];

  always #2.5 clk = ~clk;

  cmp_out_cond dut_i (
    .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .chanEnable(chanEnable),
    .polarityInv(polarityInv), .blankSel(blankSel), .blankStrobe(blankStrobe),
    .irqEnable(irqEnable), .flagClear(flagClear), .pinRoute(pinRoute),
    .chanOut(chanOut), .wakeOut(wakeOut), .irqFlag(irqFlag),
    .irqLine(irqLine), .pinOut(pinOut)
  );

  // expected conditioned output from R1..R4
  function automatic bit expOut(int ch);
    int code;
    bit v;
    if (!chanEnable[ch]) return 1'b0;
    v = rawCmp[ch] ^ polarityInv[ch];
    code = int'(blankSel[ch*4 +: 4]);
    if (code >= 1 && code <= 6 && blankStrobe[code-1]) v = 1'b0;
    return v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      histQ[c].push_back(1'b0);
      histQ[c].push_back(1'b0);
      modelFlag[c] = 1'b0;
    end
  end

  // reference model of the clocked flag path (R6, R7, R8, R11)
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      bit old;
      old = histQ[c].pop_front();
      if (!rstN) begin
        histQ[c].delete();
        histQ[c].push_back(1'b0);
        histQ[c].push_back(1'b0);
        modelFlag[c] = 1'b0;
      end else begin
        if (old && irqEnable[c]) modelFlag[c] = 1'b1;
        else if (flagClear[c]) modelFlag[c] = 1'b0;
        histQ[c].push_back(expOut(c));
      end
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      check(irqFlag == 2'b00, "R11 irqFlag in reset", irqFlag, 0);
      check(irqLine == 1'b0, "R11 irqLine in reset", irqLine, 0);
    end else begin
      bit [1:0] eo, ef;
      bit [10:0] ep;
      for (int c = 0; c < 2; c++) begin
        eo[c] = expOut(c);
        ef[c] = modelFlag[c];
      end
      for (int p = 0; p < 11; p++) ep[p] = pinRoute[p] ? eo[1] : eo[0];
      check(chanOut == eo, "R1/R2/R3/R4 chanOut", chanOut, eo);
      check(wakeOut == eo, "R5 wakeOut", wakeOut, eo);
      check(irqFlag == ef, "R6/R7/R8 irqFlag", irqFlag, ef);
      check(irqLine == (ef != 0), "R9 irqLine", irqLine, ef != 0);
      check(pinOut == ep, "R10 pinOut", pinOut, ep);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1: no blanking, plain and R4 inverted
    chanEnable = 2'b11;
    for (int i = 0; i < 8; i++) begin
      rawCmp = 2'(i);
      polarityInv = 2'(i >> 2);
      step(1);
      // R5: combinational, check within the same cycle
      #0.5;
      check(wakeOut == chanOut, "R5 same-cycle wake", wakeOut, chanOut);
    end
    // R4: disabled channel low
    chanEnable = 2'b00; rawCmp = 2'b11; step(2);
    chanEnable = 2'b10; polarityInv = 2'b01; rawCmp = 2'b00; step(2);
    chanEnable = 2'b11;
    // R2: each strobe code 1..6
    for (int k = 1; k <= 6; k++) begin
      blankSel = {4'(k), 4'(k)};
      rawCmp = 2'b11; polarityInv = 2'b00;
      blankStrobe = 6'(1 << (k - 1)); step(1);
      blankStrobe = ~6'(1 << (k - 1)); step(1);
      polarityInv = 2'b11; rawCmp = 2'b00;
      blankStrobe = 6'(1 << (k - 1)); step(1);
    end
    // R3: reserved codes ignore every strobe
    for (int k = 7; k <= 15; k++) begin
      blankSel = {4'(k), 4'(k)}; rawCmp = 2'b11; polarityInv = 2'b00;
      blankStrobe = 6'h3f; step(1);
    end
    blankSel = '0; blankStrobe = '0;
    // R6: flag latency, enable low then high
    rawCmp = 2'b00; step(3);
    irqEnable = 2'b00; rawCmp = 2'b11; step(4);
    irqEnable = 2'b01; step(4);
    irqEnable = 2'b11; step(4);
    rawCmp = 2'b00; step(4);
    // R7: clear alone
    flagClear = 2'b01; step(1); flagClear = 2'b00; step(2);
    flagClear = 2'b10; step(1); flagClear = 2'b00; step(2);
    // R8: set and clear together
    rawCmp = 2'b11; step(4);
    flagClear = 2'b11; step(1); flagClear = 2'b00; step(1);
    rawCmp = 2'b00; step(3);
    flagClear = 2'b11; step(1); flagClear = 2'b00; step(2);
    // R10: routing patterns
    rawCmp = 2'b01;
    pinRoute = 11'h000; step(1);
    pinRoute = 11'h7ff; step(1);
    pinRoute = 11'h555; step(1);
    rawCmp = 2'b10; pinRoute = 11'h2aa; step(1);
    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      rawCmp = 2'($urandom);
      chanEnable = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
      polarityInv = 2'($urandom);
      blankSel = 8'($urandom);
      blankStrobe = 6'($urandom);
      irqEnable = 2'($urandom);
      flagClear = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      pinRoute = 11'($urandom);
      step(1);
    end
    // R11: reset again mid-run
    rstN = 1'b0; step(2);
    rstN = 1'b1; step(2);
    finishRun();
  end
endmodule